// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block runs the byte-wide bus of a NAND flash device on behalf of a simple host port. The host asks for one of four operations: a command byte, an address byte, a data write, or a data read. Data operations move either one byte or a 32-bit word. A word is sent or received as four back-to-back byte cycles, lowest byte first. Each byte cycle has three phases: setup, strobe and hold. Setup runs with the latch lines and the data already on the bus. During strobe the write or read strobe is low. Hold keeps the bus steady after the strobe rises. The length of each phase is set by its own count field, which holds the wanted length minus one.

The active-low chip enable comes from a held control bit. A suspend request forces the chip enable inactive and saves that bit. A resume request puts the saved bit back. The flash ready/busy pin is synchronised before it is reported as a status bit. A global enable gates every bus strobe and latch line, and it also gates the acceptance of new requests.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: The setup phase lasts setup_cnt_i+1 clocks. The bus is already driven and the strobe is high during this phase. With WIDE_SETUP=0 only bits [1:0] of setup_cnt_i are used, so setup is at most 4 clocks. With WIDE_SETUP=1 all three bits are used, up to 8 clocks.
- R2: The strobe (nwe_o for writes, command and address; nre_o for reads) is low for exactly width_cnt_i+1 clocks. The two strobes are never low at the same time.
- R3: After the strobe rises, the hold phase lasts hold_cnt_i+1 clocks before busy_o falls or the next byte of a word starts its setup. Inside a word, the gap between strobes is therefore hold+setup+2 clocks.
- R4: op_i=0 sends wdata_i[7:0] as a command, with cle_o high for the whole byte cycle. op_i=1 sends an address byte, with ale_o high for the whole byte cycle. cle_o and ale_o are never high together. Both ignore word_i.
- R5: op_i=2 writes data, with io_oe_o high for the whole byte cycle. A single write sends wdata_i[7:0]. A word write (word_i=1) sends four bytes, least-significant first.
- R6: op_i=3 reads data. The byte on io_i is taken on the last strobe clock. A single read returns {24'h0, byte}. A word read returns the first byte in bits [7:0] and the fourth byte in bits [31:24].
- R7: busy_o is high from the clock after a request is taken until the last hold phase ends. A request made while busy_o is high is dropped. Both strobes stay high while busy_o is low.
- R8: A ce_wr_i pulse loads ce_val_i into the chip-enable bit. nce_o equals that bit: 1 means deasserted. The bit resets to 1.
- R9: A suspend_i pulse drives nce_o high and saves the bit. ce_wr_i has no effect while suspended. A resume_i pulse restores the saved bit.
- R10: ready_o follows rb_i two clocks later (1 means ready).
- R11: While en_i is low, nwe_o and nre_o stay high, cle_o, ale_o and io_oe_o stay low, and requests are dropped. This also holds in the middle of a cycle that is already running.
- R12: After reset, nwe_o and nre_o are high, cle_o, ale_o, io_oe_o and busy_o are low, and nce_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global bus enable |
| setup_cnt_i | input | 3 | Setup length minus one |
| width_cnt_i | input | 3 | Strobe length minus one |
| hold_cnt_i | input | 3 | Hold length minus one |
| req_i | input | 1 | Operation request (one clock) |
| op_i | input | 2 | 0 command, 1 address, 2 write, 3 read |
| word_i | input | 1 | Data op moves a 32-bit word |
| wdata_i | input | 32 | Command, address or write data |
| rdata_o | output | 32 | Read result |
| busy_o | output | 1 | Bus cycle in progress |
| ce_wr_i | input | 1 | Load the chip-enable bit |
| ce_val_i | input | 1 | Value for the chip-enable bit |
| suspend_i | input | 1 | Suspend pulse |
| resume_i | input | 1 | Resume pulse |
| nce_o | output | 1 | Flash chip enable, active low |
| rb_i | input | 1 | Flash ready/busy pin |
| ready_o | output | 1 | Synchronised ready status |
| io_i | input | 8 | Flash data bus in |
| io_o | output | 8 | Flash data bus out |
| io_oe_o | output | 1 | Flash data bus output enable |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| nwe_o | output | 1 | Write strobe, active low |
| nre_o | output | 1 | Read strobe, active low |

## Verification
The assertions assume that req_i is a one-clock pulse, and that suspend_i and resume_i never pulse in the same clock. They also assume the timing fields are held steady while busy_o is high, because the fields are reloaded at each phase boundary. The stimulus meets these assumptions. It changes the fields only while the block is idle. It drives every request and pulse on the falling edge for exactly one clock. It raises a second request during a busy cycle only to check that the request is dropped.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;
  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } nand_op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } nand_phase_e;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic ready_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= rb_i;
      sync_q <= meta_q;
    end
  end

  assign ready_o = sync_q;
endmodule

// File: rtl/nand_ce_ctrl.sv
module nand_ce_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_wr_i,
  input  logic ce_val_i,
  input  logic suspend_i,
  input  logic resume_i,
  output logic nce_o
);
  logic ce_q, saved_q, susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q    <= 1'b1;
      saved_q <= 1'b1;
      susp_q  <= 1'b0;
    end else if (suspend_i) begin
      if (!susp_q) saved_q <= ce_q;
      ce_q   <= 1'b1;
      susp_q <= 1'b1;
    end else if (resume_i) begin
      if (susp_q) ce_q <= saved_q;
      susp_q <= 1'b0;
    end else if (ce_wr_i && !susp_q) begin
      ce_q <= ce_val_i;
    end
  end

  assign nce_o = ce_q;

  p_suspend_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> nce_o);

  p_ce_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_wr_i && !suspend_i && !resume_i && !susp_q) |=> (nce_o == $past(ce_val_i)));
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  nand_op_e          op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  setup_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic [CNT_W-1:0]  hold_i,
  input  logic [7:0]        din_i,
  output nand_phase_e       phase_o,
  output nand_op_e          op_o,
  output logic [7:0]        dout_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  nand_phase_e       phase_q;
  nand_op_e          op_q;
  logic              word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q, rd_q;
  logic              cnt_zero, last_byte;

  assign cnt_zero  = (cnt_q == '0);
  assign last_byte = !word_q || (idx_q == IDX_W'(BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_CMD;
      word_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      rd_q    <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= setup_i;
          op_q    <= op_i;
          word_q  <= word_i && (op_i == OP_WRITE || op_i == OP_READ);
          idx_q   <= '0;
          shift_q <= wdata_i;
          rd_q    <= '0;
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase_q <= PH_STROBE;
            cnt_q   <= width_i;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: begin
          if (cnt_zero) begin
            phase_q <= PH_HOLD;
            cnt_q   <= hold_i;
            if (op_q == OP_READ)
              rd_q <= word_q ? {din_i, rd_q[DATA_W-1:8]}
                             : {{(DATA_W-8){1'b0}}, din_i};
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: begin
          if (cnt_zero) begin
            if (last_byte) phase_q <= PH_IDLE;
            else begin
              phase_q <= PH_SETUP;
              cnt_q   <= setup_i;
              idx_q   <= idx_q + 1'b1;
              shift_q <= shift_q >> 8;
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign op_o    = op_q;
  assign dout_o  = shift_q[7:0];
  assign rdata_o = rd_q;

  p_width_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SETUP && cnt_zero) |=> (phase_q == PH_STROBE && cnt_q == $past(width_i)));

  p_hold_after_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && $past(phase_q) != PH_HOLD) |-> ($past(phase_q) == PH_STROBE));
endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nand_strobe_pkg::*;
#(
  parameter bit WIDE_SETUP = 1'b0,
  parameter int DATA_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        setup_cnt_i,
  input  logic [2:0]        width_cnt_i,
  input  logic [2:0]        hold_cnt_i,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  input  logic              ce_wr_i,
  input  logic              ce_val_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  output logic              nce_o,
  input  logic              rb_i,
  output logic              ready_o,
  input  logic [7:0]        io_i,
  output logic [7:0]        io_o,
  output logic              io_oe_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              nwe_o,
  output logic              nre_o
);
  localparam int CNT_W = 3;

  logic [CNT_W-1:0] setup_eff;
  nand_phase_e      phase;
  nand_op_e         cur_op;
  logic             active, start, strobe;

  generate
    if (WIDE_SETUP) begin : g_wide_setup
      assign setup_eff = setup_cnt_i;
    end else begin : g_narrow_setup
      assign setup_eff = {1'b0, setup_cnt_i[1:0]};
    end
  endgenerate

  assign active = (phase != PH_IDLE);
  assign start  = req_i && en_i && !active;
  assign strobe = en_i && (phase == PH_STROBE);

  nand_cycle_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .op_i    (nand_op_e'(op_i)),
    .word_i  (word_i),
    .wdata_i (wdata_i),
    .setup_i (setup_eff),
    .width_i (width_cnt_i),
    .hold_i  (hold_cnt_i),
    .din_i   (io_i),
    .phase_o (phase),
    .op_o    (cur_op),
    .dout_o  (io_o),
    .rdata_o (rdata_o)
  );

  nand_ce_ctrl u_ce (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_wr_i   (ce_wr_i),
    .ce_val_i  (ce_val_i),
    .suspend_i (suspend_i),
    .resume_i  (resume_i),
    .nce_o     (nce_o)
  );

  nand_rb_sync u_rb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rb_i    (rb_i),
    .ready_o (ready_o)
  );

  assign busy_o  = active;
  assign cle_o   = en_i && active && (cur_op == OP_CMD);
  assign ale_o   = en_i && active && (cur_op == OP_ADDR);
  assign io_oe_o = en_i && active && (cur_op != OP_READ);
  assign nwe_o   = !(strobe && cur_op != OP_READ);
  assign nre_o   = !(strobe && cur_op == OP_READ);

  p_strobe_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nwe_o || nre_o);

  p_cle_ale_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (nwe_o && nre_o && !cle_o && !ale_o));

  p_disable_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (nwe_o && nre_o && !cle_o && !ale_o && !io_oe_o));
endmodule

// File: tb/nand_strobe_ctrl_bench.sv
module nand_strobe_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic en = 1'b1;
  logic [2:0] s_cfg = 3'd0, w_cfg = 3'd0, h_cfg = 3'd0;
  logic req = 1'b0, word = 1'b0;
  logic [1:0] op = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic busy, ce_wr = 1'b0, ce_val = 1'b0, susp = 1'b0, resm = 1'b0;
  logic nce, rb = 1'b0, ready;
  logic [7:0] io_in = '0, io_out;
  logic io_oe, cle, ale, nwe, nre;

  nand_strobe_ctrl u_nand_strobe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .setup_cnt_i(s_cfg), .width_cnt_i(w_cfg), .hold_cnt_i(h_cfg),
    .req_i(req), .op_i(op), .word_i(word), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy),
    .ce_wr_i(ce_wr), .ce_val_i(ce_val), .suspend_i(susp), .resume_i(resm),
    .nce_o(nce), .rb_i(rb), .ready_o(ready),
    .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe),
    .cle_o(cle), .ale_o(ale), .nwe_o(nwe), .nre_o(nre)
  );

  int n_chk = 0, n_fail = 0;
  int m_s, m_h, m_nstr, m_cle_n, m_ale_n, m_oe_n, m_busy_n;
  int m_w [4];
  int m_gap [4];
  logic [7:0] m_bytes [4];
  logic [7:0] rd_pat [4];

  task automatic check(input bit ok, input string req_tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input bit wd, input logic [31:0] d);
    int ps, cur_gap, guard;
    ps = 0; cur_gap = 0; guard = 0;
    m_s = 0; m_h = 0; m_nstr = 0; m_cle_n = 0; m_ale_n = 0; m_oe_n = 0; m_busy_n = 0;
    for (int i = 0; i < 4; i++) begin m_w[i] = 0; m_gap[i] = 0; m_bytes[i] = '0; end
    @(negedge clk);
    req = 1'b1; op = o; word = wd; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (busy && guard < 2000) begin
      guard++;
      m_busy_n++;
      if (cle) m_cle_n++;
      if (ale) m_ale_n++;
      if (io_oe) m_oe_n++;
      if (!nwe || !nre) begin
        if (ps != 1) begin
          if (ps == 2 && m_nstr < 4) m_gap[m_nstr] = cur_gap;
          cur_gap = 0;
          m_nstr++;
          ps = 1;
        end
        if (m_nstr <= 4) begin
          m_w[m_nstr-1]++;
          m_bytes[m_nstr-1] = io_out;
          io_in = rd_pat[m_nstr-1];
        end
      end else if (ps == 0) m_s++;
      else begin
        ps = 2;
        cur_gap++;
      end
      @(negedge clk);
    end
    m_h = cur_gap;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rd_pat[0] = 8'h11; rd_pat[1] = 8'h22; rd_pat[2] = 8'h33; rd_pat[3] = 8'h44;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(nwe && nre && !cle && !ale && !io_oe && !busy && nce, "R12",
          {nwe, nre, cle, ale, io_oe, busy, nce}, 7'b1100001);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 sweep of all timing fields
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 8; w++)
        for (int h = 0; h < 8; h++) begin
          s_cfg = 3'(s); w_cfg = 3'(w); h_cfg = 3'(h);
          run_op(2'd2, 1'b0, 32'(s*64 + w*8 + h));
          check(m_s == (s % 4) + 1, "R1 setup", m_s, (s % 4) + 1);
          check(m_w[0] == w + 1 && m_nstr == 1, "R2 strobe", m_w[0], w + 1);
          check(m_h == h + 1, "R3 hold", m_h, h + 1);
          check(m_bytes[0] == 8'(s*64 + w*8 + h) && m_oe_n == m_busy_n, "R5 byte",
                m_bytes[0], 8'(s*64 + w*8 + h));
        end

    s_cfg = 3'd1; w_cfg = 3'd2; h_cfg = 3'd1;
    // R4 command and address cycles
    run_op(2'd0, 1'b1, 32'h0000_0070);
    check(m_nstr == 1 && m_cle_n == m_busy_n && m_ale_n == 0 && m_bytes[0] == 8'h70,
          "R4 cmd", {m_nstr, m_cle_n, m_ale_n, m_bytes[0]}, 8'h70);
    run_op(2'd1, 1'b0, 32'h0000_00A5);
    check(m_nstr == 1 && m_ale_n == m_busy_n && m_cle_n == 0 && m_bytes[0] == 8'hA5,
          "R4 addr", {m_nstr, m_ale_n, m_cle_n, m_bytes[0]}, 8'hA5);

    // R5 word write, LSB first; R3 gaps
    run_op(2'd2, 1'b1, 32'hA1B2_C3D4);
    check(m_nstr == 4, "R5 word count", m_nstr, 4);
    check({m_bytes[3], m_bytes[2], m_bytes[1], m_bytes[0]} == 32'hA1B2_C3D4, "R5 word order",
          {m_bytes[3], m_bytes[2], m_bytes[1], m_bytes[0]}, 32'hA1B2_C3D4);
    for (int i = 1; i < 4; i++)
      check(m_gap[i] == 1 + 1 + 2, "R3 gap", m_gap[i], 4);

    // R6 reads
    run_op(2'd3, 1'b1, 32'h0);
    check(rdata == 32'h4433_2211 && m_oe_n == 0, "R6 word read", rdata, 32'h4433_2211);
    rd_pat[0] = 8'h5A;
    run_op(2'd3, 1'b0, 32'h0);
    check(rdata == 32'h0000_005A, "R6 byte read", rdata, 32'h5A);

    // R7 request while busy is dropped
    @(negedge clk); req = 1'b1; op = 2'd2; word = 1'b0; wdata = 32'h33;
    @(negedge clk); req = 1'b1; op = 2'd0;
    check(busy, "R7 busy", busy, 1);
    @(negedge clk); req = 1'b0;
    m_cle_n = 0;
    while (busy) begin if (cle) m_cle_n++; @(negedge clk); end
    repeat (3) begin
      check(!busy && nwe && !cle, "R7 dropped", {busy, nwe, cle}, 3'b010);
      @(negedge clk);
    end
    check(m_cle_n == 0, "R7 no cmd", m_cle_n, 0);

    // R11 enable low
    en = 1'b0;
    @(negedge clk); req = 1'b1; op = 2'd2;
    @(negedge clk); req = 1'b0;
    repeat (4) begin
      check(!busy && nwe && nre && !io_oe, "R11 idle", {busy, nwe, nre, io_oe}, 4'b0110);
      @(negedge clk);
    end
    en = 1'b1;
    s_cfg = 3'd0; w_cfg = 3'd7;
    @(negedge clk); req = 1'b1; op = 2'd0;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    check(!nwe && cle, "R11 strobe live", {nwe, cle}, 2'b01);
    en = 1'b0;
    @(negedge clk);
    check(nwe && nre && !cle && !ale && !io_oe, "R11 gated", {nwe, cle, io_oe}, 3'b100);
    while (busy) @(negedge clk);
    en = 1'b1;

    // R8 chip enable bit
    ce_wr = 1'b1; ce_val = 1'b0;
    @(negedge clk); ce_wr = 1'b0;
    check(nce == 1'b0, "R8 assert", nce, 0);
    ce_wr = 1'b1; ce_val = 1'b1;
    @(negedge clk); ce_wr = 1'b0;
    check(nce == 1'b1, "R8 deassert", nce, 1);
    ce_wr = 1'b1; ce_val = 1'b0;
    @(negedge clk); ce_wr = 1'b0;

    // R9 suspend / resume
    susp = 1'b1; @(negedge clk); susp = 1'b0;
    check(nce == 1'b1, "R9 forced", nce, 1);
    ce_wr = 1'b1; ce_val = 1'b1; @(negedge clk); ce_wr = 1'b0;
    check(nce == 1'b1, "R9 write ignored", nce, 1);
    resm = 1'b1; @(negedge clk); resm = 1'b0;
    check(nce == 1'b0, "R9 restored", nce, 0);
    ce_wr = 1'b1; ce_val = 1'b1; @(negedge clk); ce_wr = 1'b0;
    susp = 1'b1; @(negedge clk); susp = 1'b0;
    resm = 1'b1; @(negedge clk); resm = 1'b0;
    check(nce == 1'b1, "R9 restored high", nce, 1);

    // R10 ready synchroniser
    rb = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R10 one clock", ready, 0);
    @(negedge clk);
    check(ready == 1'b1, "R10 two clocks", ready, 1);
    rb = 1'b0;
    @(negedge clk);
    check(ready == 1'b1, "R10 fall one", ready, 1);
    @(negedge clk);
    check(ready == 1'b0, "R10 fall two", ready, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule